// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-facing timing engine of a small 8-bit processor whose low address byte and data byte share one set of pins. The core hands it one transfer at a time (a cycle kind, a 16-bit address, write data, a flag selecting the long opcode-fetch form and a flag that suppresses the address latch strobe). The sequencer then walks the bus through its clock states. It drives the high address byte, the shared address/data byte, the address latch strobe (ALE), the active-low read, write and interrupt-acknowledge strobes, the memory/IO select and the two status bits. It inserts wait states while the bus READY input is low, captures read data and returns it with a one-cycle done pulse.

Between transfers the block can park the bus. A hold request floats every shared pin and raises a hold acknowledge. A halt request floats the same pins and forces the status bits to 00. Each tristate-capable output comes with its own enable, so the pad ring or a testbench can see the floated states.

The request side is a valid/ready channel. The core raises `req_valid` with stable fields and keeps them until it sees `req_ready` high at a clock edge. `req_ready` is high only while the bus is idle and neither hold nor halt is asked for, so the core is held off for the whole transfer. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the core must take when it appears.

Top module: `mbus_seq`

## Requirements
- R1: Cycle kind codes are {io_m, sta[1], sta[0]}: opcode fetch 011, memory read 010, memory write 001, IO read 110, IO write 101, interrupt acknowledge 111. From T1 to the last state of the transfer, io_m/sta carry the code of the kind and io_m_oe is 1. Outside a transfer, sta is 00 and io_m_oe is 0.
- R2: ALE is 1 only in T1. In T1, ad_out carries addr[7:0] with ad_oe=1, and addr_hi_oe=1.
- R3: A transfer other than opcode fetch takes exactly three states (T1, T2, T3) plus waits, starting the cycle after acceptance and returning to idle after T3.
- R4: An opcode fetch adds T4 (req_long=0) or T4–T6 (req_long=1). In those states, ad_oe=0, all strobes are 1, the status is kept, and addr_hi is addr[15:8].
- R5: For IO read and IO write, addr_hi carries addr[7:0] (the port number) throughout the transfer. For every other kind it carries addr[15:8].
- R6: In T2, waits and T3, rd_n=0 for fetch, memory read and IO read; wr_n=0 for memory write and IO write, with ad_out=wdata and ad_oe=1; inta_n=0 for interrupt acknowledge. ad_oe=0 for every non-write kind. At most one strobe is low at a time.
- R7: bus_ready is sampled at the edge ending T2 and at the edge ending each wait state. Low inserts another wait state, with pins identical to T2.
- R8: For fetch, memory read, IO read and acknowledge, ad_in is captured at the edge ending T3. rsp_valid is 1 for exactly the following cycle, with that byte on rsp_data. A write also gives the pulse.
- R9: With req_no_ale=1, ALE stays 0 for the whole transfer. Every other pin behaves as without the flag.
- R10: hold_req seen at an idle edge moves the bus to hold on the next cycle. In hold, hold_ack=1; io_m_oe, addr_hi_oe, ad_oe and strobe_oe are 0; ALE is 0. Hold ends one cycle after hold_req is seen low. Hold takes priority over halt and over a request.
- R11: halt_req seen at an idle edge (without hold_req) moves the bus to halt. In halt, the same enables are 0, ALE is 0, sta=00 and hold_ack=0, until halt_req is seen low.
- R12: req_ready is 1 only in idle with hold_req and halt_req low. A request presented while not ready is kept by the core and accepted once ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_kind | input | 3 | Cycle kind code (R1) |
| req_addr | input | 16 | Transfer address or port number in [7:0] |
| req_wdata | input | 8 | Write data |
| req_long | input | 1 | Opcode fetch runs six states |
| req_no_ale | input | 1 | Suppress ALE for this transfer |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | 8 | Captured read byte |
| bus_ready | input | 1 | Bus ready, low requests wait states |
| hold_req | input | 1 | Bus hold request |
| halt_req | input | 1 | Enter halt state |
| hold_ack | output | 1 | Bus is in hold |
| addr_hi | output | 8 | High address byte |
| addr_hi_oe | output | 1 | Enable for addr_hi |
| ad_out | output | 8 | Shared address/data byte out |
| ad_oe | output | 1 | Enable for ad_out |
| ad_in | input | 8 | Shared address/data byte in |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| strobe_oe | output | 1 | Enable for rd_n and wr_n |
| io_m | output | 1 | Memory/IO select |
| io_m_oe | output | 1 | Enable for io_m |
| sta | output | 2 | Status bits |

## Verification
The main sweep crosses all six cycle kinds with both fetch lengths, both ALE settings and zero, one or two wait states. Every pin is compared in every state against values worked out from the kind code. This separates the strobe choice, the port mirroring on the high byte, the bus turnaround for reads against writes, and the four- and six-state fetch tails. Addresses, write data and read data change from transfer to transfer by arithmetic steps, so a mixed-up byte lane or a stale capture shows up as a wrong value. Separate sequences cover hold, halt, hold winning over halt, and a request parked during hold that must go through afterwards.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam logic [2:0] K_MWR   = 3'b001;
  localparam logic [2:0] K_MRD   = 3'b010;
  localparam logic [2:0] K_FETCH = 3'b011;
  localparam logic [2:0] K_IOWR  = 3'b101;
  localparam logic [2:0] K_IORD  = 3'b110;
  localparam logic [2:0] K_ACK   = 3'b111;

  typedef enum logic [3:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_T4, ST_T5, ST_T6, ST_HOLD, ST_HALT
  } tstate_e;

  function automatic logic k_reads(input logic [2:0] k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic k_writes(input logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic k_port(input logic [2:0] k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

endpackage

// File: rtl/mbus_fsm.sv
module mbus_fsm
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_long,
  input  logic              req_no_ale,
  input  logic              bus_ready,
  input  logic              hold_req,
  input  logic              halt_req,
  input  logic [DATA_W-1:0] ad_in,
  output tstate_e           st,
  output logic [2:0]        cur_kind,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              cur_no_ale,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  tstate_e st_nx;
  logic    cur_long;
  logic    accept;

  assign req_ready = (st == ST_IDLE) && !hold_req && !halt_req;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: begin
        if (hold_req)       st_nx = ST_HOLD;
        else if (halt_req)  st_nx = ST_HALT;
        else if (req_valid) st_nx = ST_T1;
      end
      ST_T1:        st_nx = ST_T2;
      ST_T2, ST_TW: st_nx = bus_ready ? ST_T3 : ST_TW;
      ST_T3:        st_nx = (cur_kind == K_FETCH) ? ST_T4 : ST_IDLE;
      ST_T4:        st_nx = cur_long ? ST_T5 : ST_IDLE;
      ST_T5:        st_nx = ST_T6;
      ST_T6:        st_nx = ST_IDLE;
      ST_HOLD:      if (!hold_req) st_nx = ST_IDLE;
      ST_HALT:      if (!halt_req) st_nx = ST_IDLE;
      default:      st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_kind   <= '0;
      cur_addr   <= '0;
      cur_wdata  <= '0;
      cur_long   <= 1'b0;
      cur_no_ale <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      st        <= st_nx;
      rsp_valid <= (st == ST_T3);
      if (accept) begin
        cur_kind   <= req_kind;
        cur_addr   <= req_addr;
        cur_wdata  <= req_wdata;
        cur_long   <= req_long;
        cur_no_ale <= req_no_ale;
      end
      if (st == ST_T3 && (k_reads(cur_kind) || cur_kind == K_ACK))
        rsp_data <= ad_in;
    end
  end

  p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> st == ST_T1);
  p_wait_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T2 && !bus_ready) |=> st == ST_TW);
  p_wait_leave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_T2 || st == ST_TW) && bus_ready) |=> st == ST_T3);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T3) |=> rsp_valid && !$past(rsp_valid));
  p_short_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T4 && !cur_long) |=> st == ST_IDLE);
  p_hold_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && hold_req) |=> st == ST_HOLD);

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           st,
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              no_ale,
  output logic [DATA_W-1:0] addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  output logic              strobe_oe,
  output logic              io_m,
  output logic              io_m_oe,
  output logic [1:0]        sta
);

  logic in_cycle, data_ph;

  assign in_cycle = (st == ST_T1) || (st == ST_T2) || (st == ST_TW) || (st == ST_T3) ||
                    (st == ST_T4) || (st == ST_T5) || (st == ST_T6);
  assign data_ph  = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);

  always_comb begin
    addr_hi    = '0;
    addr_hi_oe = 1'b0;
    ad_out     = '0;
    ad_oe      = 1'b0;
    ale        = 1'b0;
    rd_n       = 1'b1;
    wr_n       = 1'b1;
    inta_n     = 1'b1;
    strobe_oe  = !((st == ST_HOLD) || (st == ST_HALT));
    io_m       = 1'b0;
    io_m_oe    = 1'b0;
    sta        = 2'b00;
    if (in_cycle) begin
      io_m       = kind[2];
      sta        = kind[1:0];
      io_m_oe    = 1'b1;
      addr_hi_oe = 1'b1;
      addr_hi    = k_port(kind) ? addr[DATA_W-1:0] : addr[ADDR_W-1:DATA_W];
    end
    if (st == ST_T1) begin
      ale    = !no_ale;
      ad_oe  = 1'b1;
      ad_out = addr[DATA_W-1:0];
    end
    if (data_ph) begin
      rd_n   = !k_reads(kind);
      wr_n   = !k_writes(kind);
      inta_n = !(kind == K_ACK);
      ad_oe  = k_writes(kind);
      ad_out = wdata;
    end
  end

  p_ale_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe && addr_hi_oe && io_m_oe);
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);
  p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !inta_n) |-> !ad_oe);

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_long,
  input  logic              req_no_ale,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              bus_ready,
  input  logic              hold_req,
  input  logic              halt_req,
  output logic              hold_ack,
  output logic [DATA_W-1:0] addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  output logic              strobe_oe,
  output logic              io_m,
  output logic              io_m_oe,
  output logic [1:0]        sta
);

  tstate_e           st;
  logic [2:0]        cur_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_no_ale;

  mbus_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_long(req_long), .req_no_ale(req_no_ale),
    .bus_ready(bus_ready), .hold_req(hold_req), .halt_req(halt_req),
    .ad_in(ad_in), .st(st),
    .cur_kind(cur_kind), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .cur_no_ale(cur_no_ale),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  mbus_pins #(.DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .st(st),
    .kind(cur_kind), .addr(cur_addr), .wdata(cur_wdata), .no_ale(cur_no_ale),
    .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .strobe_oe(strobe_oe),
    .io_m(io_m), .io_m_oe(io_m_oe), .sta(sta)
  );

  assign hold_ack = (st == ST_HOLD);

  p_hold_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> !(io_m_oe || addr_hi_oe || ad_oe || strobe_oe || ale));
  p_halt_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT) |-> (sta == 2'b00) && !io_m_oe && !ad_oe && !ale);
  p_status_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_m_oe && st != ST_T1) |-> $stable({io_m, sta}));

endmodule

// File: tb/mbus_seq_test.sv
module mbus_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_long = 1'b0, req_no_ale = 1'b0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        bus_ready = 1'b1, hold_req = 1'b0, halt_req = 1'b0, hold_ack;
  logic [7:0]  addr_hi, ad_out;
  logic [7:0]  ad_in = '0;
  logic        addr_hi_oe, ad_oe, ale, rd_n, wr_n, inta_n, strobe_oe, io_m, io_m_oe;
  logic [1:0]  sta;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [2:0]  e_kind;
  logic [15:0] e_addr;
  logic [7:0]  e_wdata;
  logic        e_noale;

  localparam int PH_IDLE = 0, PH_T1 = 1, PH_MID = 2, PH_TAIL = 3, PH_HOLD = 4, PH_HALT = 5;

  always #5 clk = ~clk;

  mbus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_long(req_long), .req_no_ale(req_no_ale),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_ready(bus_ready),
    .hold_req(hold_req), .halt_req(halt_req), .hold_ack(hold_ack),
    .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
    .strobe_oe(strobe_oe), .io_m(io_m), .io_m_oe(io_m_oe), .sta(sta)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_pins(input int ph);
    logic rd, wr, ack, port, cyc;
    rd   = (e_kind == 3'b011) || (e_kind == 3'b010) || (e_kind == 3'b110);
    wr   = (e_kind == 3'b001) || (e_kind == 3'b101);
    ack  = (e_kind == 3'b111);
    port = (e_kind == 3'b110) || (e_kind == 3'b101);
    cyc  = (ph == PH_T1) || (ph == PH_MID) || (ph == PH_TAIL);
    chk("R1", "io_m_oe", io_m_oe, cyc);
    chk("R1", "status", {io_m, sta}, cyc ? e_kind : 3'b000);
    chk(ph == PH_T1 ? (e_noale ? "R9" : "R2") : "R2", "ale", ale, (ph == PH_T1) && !e_noale);
    chk("R5", "addr_hi_oe", addr_hi_oe, cyc);
    if (cyc) chk("R5", "addr_hi", addr_hi, port ? e_addr[7:0] : e_addr[15:8]);
    case (ph)
      PH_T1: begin
        chk("R2", "ad_oe", ad_oe, 1);
        chk("R2", "ad_out", ad_out, e_addr[7:0]);
        chk("R6", "strobes", {rd_n, wr_n, inta_n}, 3'b111);
      end
      PH_MID: begin
        chk("R6", "ad_oe", ad_oe, wr);
        if (wr) chk("R6", "ad_out", ad_out, e_wdata);
        chk("R6", "strobes", {rd_n, wr_n, inta_n}, {!rd, !wr, !ack});
      end
      PH_TAIL: begin
        chk("R4", "ad_oe", ad_oe, 0);
        chk("R4", "strobes", {rd_n, wr_n, inta_n}, 3'b111);
      end
      default: begin
        chk(ph == PH_HOLD ? "R10" : (ph == PH_HALT ? "R11" : "R1"), "ad_oe", ad_oe, 0);
        chk(ph == PH_HALT ? "R11" : "R10", "inta_n", inta_n, 1);
      end
    endcase
    chk(ph == PH_HOLD ? "R10" : "R11", "strobe_oe", strobe_oe, !(ph == PH_HOLD || ph == PH_HALT));
    chk("R10", "hold_ack", hold_ack, ph == PH_HOLD);
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                           input logic lng, input logic nale, input int nw, input logic [7:0] rdat);
    logic cap;
    cap = (k == 3'b011) || (k == 3'b010) || (k == 3'b110) || (k == 3'b111);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = wd; req_long = lng; req_no_ale = nale;
    e_kind = k; e_addr = a; e_wdata = wd; e_noale = nale;
    chk("R12", "req_ready idle", req_ready, 1);
    @(negedge clk);
    req_valid = 0; req_kind = 3'b000; req_addr = 16'hFFFF; req_wdata = 8'hEE;
    bus_ready = (nw == 0);
    check_pins(PH_T1);
    chk("R12", "req_ready busy", req_ready, 0);
    @(negedge clk);
    check_pins(PH_MID);
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      check_pins(PH_MID);
      chk("R7", "rsp_valid in wait", rsp_valid, 0);
      bus_ready = (w == nw - 1);
    end
    @(negedge clk);
    check_pins(PH_MID);
    ad_in = rdat;
    @(negedge clk);
    ad_in = 8'h00;
    chk("R8", "rsp_valid", rsp_valid, 1);
    if (cap) chk("R8", "rsp_data", rsp_data, rdat);
    if (k == 3'b011) begin
      check_pins(PH_TAIL);
      if (lng) begin
        @(negedge clk); check_pins(PH_TAIL);
        chk("R8", "rsp_valid once", rsp_valid, 0);
        @(negedge clk); check_pins(PH_TAIL);
      end
      @(negedge clk);
      chk("R4", "rsp_valid end", rsp_valid, 0);
    end
    check_pins(PH_IDLE);
    chk("R3", "req_ready after", req_ready, 1);
  endtask

  initial begin
    logic [2:0] kinds [6];
    int n;
    kinds = '{3'b011, 3'b010, 3'b001, 3'b110, 3'b101, 3'b111};
    n = 0;
    e_kind = 0; e_addr = 0; e_wdata = 0; e_noale = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_pins(PH_IDLE);
    chk("R12", "reset ready", req_ready, 1);
    chk("R8", "reset rsp_valid", rsp_valid, 0);
    for (int ki = 0; ki < 6; ki++)
      for (int lg = 0; lg < 2; lg++)
        for (int na = 0; na < 2; na++)
          for (int nw = 0; nw < 3; nw++) begin
            run_cycle(kinds[ki], 16'(n * 16'h3A5 + 16'h0F1), 8'(n * 7 + 3), lg[0], na[0], nw,
                      8'(n * 13 + 8'h5A));
            n++;
          end
    // R10: hold, with a request parked against it
    @(negedge clk);
    hold_req = 1;
    @(negedge clk);
    check_pins(PH_HOLD);
    req_valid = 1; req_kind = 3'b010; req_addr = 16'hBEEF; req_wdata = 0; req_long = 0; req_no_ale = 0;
    chk("R12", "ready in hold", req_ready, 0);
    @(negedge clk);
    check_pins(PH_HOLD);
    hold_req = 0;
    @(negedge clk);
    e_noale = 0;
    check_pins(PH_IDLE);
    chk("R12", "ready after hold", req_ready, 1);
    e_kind = 3'b010; e_addr = 16'hBEEF;
    @(negedge clk);
    req_valid = 0;
    bus_ready = 1;
    check_pins(PH_T1);
    @(negedge clk); check_pins(PH_MID);
    @(negedge clk); check_pins(PH_MID); ad_in = 8'hC3;
    @(negedge clk);
    chk("R12", "parked rsp", rsp_valid, 1);
    chk("R12", "parked data", rsp_data, 8'hC3);
    // R11: halt
    @(negedge clk);
    halt_req = 1;
    @(negedge clk);
    check_pins(PH_HALT);
    chk("R11", "ready in halt", req_ready, 0);
    @(negedge clk);
    check_pins(PH_HALT);
    halt_req = 0;
    @(negedge clk);
    check_pins(PH_IDLE);
    // R10 priority over halt
    hold_req = 1; halt_req = 1;
    @(negedge clk);
    check_pins(PH_HOLD);
    hold_req = 0; halt_req = 0;
    @(negedge clk);
    check_pins(PH_IDLE);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule